// File: doc/BRIEF.md
# Indirect Register Front End with Command Interrupts

This block is the host-facing register front end of a small bus-interface controller. The host sees only two byte locations. One is an address/status port: writing it chooses which internal register the next value access touches, and reading it returns a short status byte. The other is a value port, which reads or writes the chosen register. Writing the value port moves the select pointer on by one, so the host can fill a run of consecutive registers (such as the three byte-count registers) with a single pointer load.

The block decodes the command register. It handles a controller reset, a select-with-attention toward a target ID, and a transfer-information command that arms a 24-bit byte counter. During a transfer, each write to the data register is forwarded to a target stub. When the counted number of bytes has been sent, the block writes a completion code to the status register (CSR) and raises an interrupt. The interrupt is cleared when the host reads the CSR, when it writes the control register with the end-of-disconnect bit, or when it issues a new transfer command.

Top module: `rf_front_top`

## Requirements
- R1: Only byte offsets 3 (address/status port) and 7 (value port) respond. Port index = (offset − 3) / 4. An access at any other offset changes no state and reads back 0.
- R2: A write to offset 3 loads the select pointer with the written byte masked to the register count (32 by default, so 0x3F loads 0x1F).
- R3: A read of offset 3 returns the status byte. Bit 0 (buffer ready) is always 1, bit 7 equals the interrupt-pending flag, and all other bits are 0. The `irq` output equals the same flag.
- R4: A write to offset 7 stores the byte in the selected register, and the pointer then increments modulo the register count. A read of offset 7 returns the selected register and leaves the pointer unchanged.
- R5: A value-port read while the CSR (address 0x17) is selected clears the interrupt-pending flag.
- R6: A write to the control register (0x01) with bit 3 set clears the interrupt-pending flag. With bit 3 clear, the flag is unchanged.
- R7: The command register (0x18) is decoded on bits 6:0. Bit 7 (single-byte flag) is ignored for decoding. Code 0x00 (reset) sets interrupt-pending and loads the CSR with 0x01.
- R8: Code 0x06 (select with attention) sets interrupt-pending. If `tgt_present[selid[2:0]]` is 1 (select-ID register 0x15), the CSR becomes 0x8A (phase change with command phase 2). Otherwise the CSR becomes 0x42 (selection timeout).
- R9: Code 0x20 (transfer information) loads the count as {0x12, 0x13, 0x14} (high, middle, low), zeroes the byte position and clears interrupt-pending. A non-zero count starts a transfer.
- R10: In a transfer, each write to the data register (0x19) emits one byte on `tgt_valid`/`tgt_byte` one cycle later. The byte that reaches the count also asserts `tgt_last`, sets interrupt-pending and loads the CSR with 0x18 (transferred, data-out phase 0) when `tgt_wants_out` is 1, or 0x19 (data-in phase 1) when it is 0.
- R11: A data-register write with no transfer active, including after the count has been reached, pulses `err` for one cycle. It forwards no byte and leaves interrupt-pending and the CSR unchanged.
- R12: Any other command code leaves the CSR and interrupt-pending unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_off | input | 3 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data during a read access, else 0 |
| irq | output | 1 | Interrupt-pending flag |
| tgt_present | input | 8 | One bit per target ID: target answers selection |
| tgt_wants_out | input | 1 | Target stub requests data-out direction |
| tgt_valid | output | 1 | Forwarded transfer byte valid |
| tgt_byte | output | 8 | Forwarded transfer byte |
| tgt_last | output | 1 | Byte that completed the count |
| err | output | 1 | One-cycle pulse on a data write with no transfer active |

## Verification
The bench targets the pointer: the increment after a value write but not after a read, wrap-around at the top of the file, and masking of a wide address. A design that advanced on reads, or failed to wrap, would put the next byte-count write into the wrong register. It checks that the single-byte flag does not hide a reset command, and that an unknown code leaves the CSR intact, so a decoder that compared all eight bits would fail one of the two. It runs transfers in both directions and then writes one byte past the count. A counter that is off by one would finish early or late, and a design without the guard would forward the stray byte or disturb the CSR. It also checks that a stray offset leaves the pointer unchanged.

// File: rtl/rf_front_pkg.sv
package rf_front_pkg;
  localparam int unsigned BYTE_W = 8;

  // register addresses (the count registers must stay consecutive)
  localparam logic [7:0] REG_CTRL    = 8'h01;
  localparam logic [7:0] REG_CNT_HI  = 8'h12;
  localparam logic [7:0] REG_CNT_MID = 8'h13;
  localparam logic [7:0] REG_CNT_LO  = 8'h14;
  localparam logic [7:0] REG_SELID   = 8'h15;
  localparam logic [7:0] REG_CSR     = 8'h17;
  localparam logic [7:0] REG_CMD     = 8'h18;
  localparam logic [7:0] REG_DATA    = 8'h19;

  localparam int unsigned CTRL_EOD_BIT  = 3;
  localparam logic [7:0]  CMD_CODE_MASK = 8'h7F;

  localparam logic [7:0] OP_RESET   = 8'h00;
  localparam logic [7:0] OP_SEL_ATN = 8'h06;
  localparam logic [7:0] OP_XFER    = 8'h20;

  localparam logic [7:0] CSR_RESET_DONE = 8'h01;
  localparam logic [7:0] CSR_SEL_TMO    = 8'h42;
  localparam logic [7:0] CSR_PHASE_CHG  = 8'h88;
  localparam logic [7:0] CSR_XFERRED    = 8'h18;
  localparam logic [7:0] PH_DATA_OUT    = 8'h00;
  localparam logic [7:0] PH_DATA_IN     = 8'h01;
  localparam logic [7:0] PH_COMMAND     = 8'h02;
endpackage

// File: rtl/rf_sel_ptr.sv
module rf_sel_ptr #(
  parameter int unsigned PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [7:0]       load_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (load)      ptr_d = load_val[PTR_W-1:0];
    else if (step) ptr_d = ptr + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ptr <= '0;
    else if (load || step)  ptr <= ptr_d;
  end

  // R4: a value write moves the pointer on by exactly one
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (ptr == $past(ptr) + PTR_W'(1)));
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned PTR_W = $clog2(NREGS),
  parameter int unsigned ENG_ADDR = 23
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_we,
  input  logic [PTR_W-1:0]           host_sel,
  input  logic [7:0]                 host_wdata,
  input  logic                       eng_we,
  input  logic [7:0]                 eng_wdata,
  output logic [NREGS-1:0][7:0]      regs
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic       we_g;
    logic [7:0] d_g;
    always_comb begin
      we_g = 1'b0;
      d_g  = regs[g];
      if (host_we && host_sel == PTR_W'(g)) begin
        we_g = 1'b1;
        d_g  = host_wdata;
      end
      if (g == ENG_ADDR && eng_we) begin
        we_g = 1'b1;
        d_g  = eng_wdata;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    regs[g] <= '0;
      else if (we_g) regs[g] <= d_g;
    end
  end
endmodule

// File: rtl/rf_cmd_engine.sv
module rf_cmd_engine
  import rf_front_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       wr_cmd,
  input  logic       wr_data,
  input  logic       rd_csr,
  input  logic [7:0] wdata,
  input  logic [7:0] cnt_hi,
  input  logic [7:0] cnt_mid,
  input  logic [7:0] cnt_lo,
  input  logic [7:0] selid,
  input  logic [7:0] tgt_present,
  input  logic       tgt_wants_out,
  output logic       csr_we,
  output logic [7:0] csr_val,
  output logic       irq,
  output logic       tgt_valid,
  output logic [7:0] tgt_byte,
  output logic       tgt_last,
  output logic       err
);
  logic             irq_d, act_q, act_d, err_d, tv_d, tl_d;
  logic [7:0]       tb_d;
  logic [CNT_W-1:0] pos_q, pos_d, cnt_q, cnt_d, pos_inc;

  assign pos_inc = pos_q + CNT_W'(1);

  always_comb begin
    irq_d = irq; act_d = act_q; pos_d = pos_q; cnt_d = cnt_q;
    err_d = 1'b0; tv_d = 1'b0; tl_d = 1'b0; tb_d = tgt_byte;
    csr_we = 1'b0; csr_val = '0;
    if (rd_csr) irq_d = 1'b0;
    if (wr_ctrl && wdata[CTRL_EOD_BIT]) irq_d = 1'b0;
    if (wr_cmd) begin
      case (wdata & CMD_CODE_MASK)
        OP_RESET: begin
          irq_d = 1'b1; act_d = 1'b0;
          csr_we = 1'b1; csr_val = CSR_RESET_DONE;
        end
        OP_SEL_ATN: begin
          irq_d = 1'b1; csr_we = 1'b1;
          csr_val = tgt_present[selid[2:0]] ? (CSR_PHASE_CHG | PH_COMMAND) : CSR_SEL_TMO;
        end
        OP_XFER: begin
          cnt_d = CNT_W'({cnt_hi, cnt_mid, cnt_lo});
          pos_d = '0;
          irq_d = 1'b0;
          act_d = |{cnt_hi, cnt_mid, cnt_lo};
        end
        default: ;
      endcase
    end
    if (wr_data) begin
      if (act_q) begin
        tv_d = 1'b1; tb_d = wdata; pos_d = pos_inc;
        if (pos_inc == cnt_q) begin
          act_d = 1'b0; tl_d = 1'b1; irq_d = 1'b1; csr_we = 1'b1;
          csr_val = CSR_XFERRED | (tgt_wants_out ? PH_DATA_OUT : PH_DATA_IN);
        end
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0; act_q <= 1'b0; pos_q <= '0; cnt_q <= '0;
      err <= 1'b0; tgt_valid <= 1'b0; tgt_last <= 1'b0; tgt_byte <= '0;
    end else begin
      irq <= irq_d; act_q <= act_d; pos_q <= pos_d; cnt_q <= cnt_d;
      err <= err_d; tgt_valid <= tv_d; tgt_last <= tl_d;
      if (tv_d) tgt_byte <= tb_d;
    end
  end

  // R7: a reset command always leaves an interrupt pending
  assert_reset_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && ((wdata & CMD_CODE_MASK) == OP_RESET)) |=> irq);
  // R11: a stray data write flags an error and forwards nothing
  assert_stray_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !act_q) |=> (err && !tgt_valid && $stable(irq)));
  // R10: the completing byte is also a forwarded byte
  assert_last_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_last |-> tgt_valid);
  // R9: a transfer command leaves no interrupt pending
  assert_xfer_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && ((wdata & CMD_CODE_MASK) == OP_XFER)) |=> !irq);
endmodule

// File: rtl/rf_front_top.sv
module rf_front_top
  import rf_front_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  parameter int unsigned CNT_W = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       bus_we,
  input  logic [2:0] bus_off,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  input  logic [7:0] tgt_present,
  input  logic       tgt_wants_out,
  output logic       tgt_valid,
  output logic [7:0] tgt_byte,
  output logic       tgt_last,
  output logic       err
);
  localparam int unsigned PTR_W = $clog2(NREGS);
  localparam logic [PTR_W-1:0] SEL_CTRL = PTR_W'(REG_CTRL);
  localparam logic [PTR_W-1:0] SEL_CSR  = PTR_W'(REG_CSR);
  localparam logic [PTR_W-1:0] SEL_CMD  = PTR_W'(REG_CMD);
  localparam logic [PTR_W-1:0] SEL_DATA = PTR_W'(REG_DATA);

  logic                  hit, port_idx;
  logic                  addr_wr, addr_rd, val_wr, val_rd;
  logic [PTR_W-1:0]      ptr;
  logic [NREGS-1:0][7:0] regs;
  logic                  csr_we;
  logic [7:0]            csr_val;

  // offset 3 -> port 0, offset 7 -> port 1: (off - 3) / 4
  assign hit      = bus_en && (bus_off[1:0] == 2'b11);
  assign port_idx = bus_off[2];
  assign addr_wr  = hit && !port_idx && bus_we;
  assign addr_rd  = hit && !port_idx && !bus_we;
  assign val_wr   = hit && port_idx && bus_we;
  assign val_rd   = hit && port_idx && !bus_we;

  always_comb begin
    bus_rdata = '0;
    if (addr_rd)     bus_rdata = {irq, 6'b0, 1'b1};
    else if (val_rd) bus_rdata = regs[ptr];
  end

  rf_sel_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(addr_wr), .load_val(bus_wdata),
    .step(val_wr), .ptr(ptr)
  );

  rf_bank #(.NREGS(NREGS), .PTR_W(PTR_W), .ENG_ADDR(int'(REG_CSR) % NREGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .host_we(val_wr), .host_sel(ptr),
    .host_wdata(bus_wdata), .eng_we(csr_we), .eng_wdata(csr_val), .regs(regs)
  );

  rf_cmd_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(val_wr && ptr == SEL_CTRL),
    .wr_cmd (val_wr && ptr == SEL_CMD),
    .wr_data(val_wr && ptr == SEL_DATA),
    .rd_csr (val_rd && ptr == SEL_CSR),
    .wdata(bus_wdata),
    .cnt_hi(regs[PTR_W'(REG_CNT_HI)]), .cnt_mid(regs[PTR_W'(REG_CNT_MID)]),
    .cnt_lo(regs[PTR_W'(REG_CNT_LO)]), .selid(regs[PTR_W'(REG_SELID)]),
    .tgt_present(tgt_present), .tgt_wants_out(tgt_wants_out),
    .csr_we(csr_we), .csr_val(csr_val), .irq(irq),
    .tgt_valid(tgt_valid), .tgt_byte(tgt_byte), .tgt_last(tgt_last), .err(err)
  );

  // R5: reading the CSR through the value port drops the interrupt
  assert_csr_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (val_rd && ptr == SEL_CSR) |=> !irq);
  // R4: a value read leaves the pointer where it was
  assert_read_keeps_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (val_rd) |=> $stable(ptr));
  // R1: an access at a stray offset changes neither pointer nor interrupt
  assert_stray_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_off[1:0] != 2'b11) |=> ($stable(ptr) && $stable(irq)));
endmodule

// File: tb/rf_front_top_tb_top.sv
module rf_front_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_off = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, tgt_valid, tgt_last, err;
  logic [7:0] tgt_byte;
  logic [7:0] tgt_present = 8'b0010_0000;
  logic       tgt_wants_out = 1'b0;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;  // 50 MHz

  rf_front_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .tgt_present(tgt_present), .tgt_wants_out(tgt_wants_out),
    .tgt_valid(tgt_valid), .tgt_byte(tgt_byte), .tgt_last(tgt_last), .err(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] off, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_off = off; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] off, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_off = off;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    wr(3'd3, a); wr(3'd7, d);
  endtask

  task automatic rreg(input logic [7:0] a, output logic [7:0] d);
    wr(3'd3, a); rd(3'd7, d);
  endtask

  task automatic status_irq(input string req, input logic exp);
    logic [7:0] s;
    rd(3'd3, s);
    chk(req, {24'd0, s}, {24'd0, exp, 6'b0, 1'b1});
    chk(req, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic t_reset_state;
    status_irq("R3 reset status", 1'b0);
    rd(3'd7, rv);
    chk("R4 reg0 after reset", {24'd0, rv}, 32'h0);
  endtask

  task automatic t_pointer;
    wr(3'd3, 8'h3F);
    wr(3'd7, 8'hA5);            // stores at 0x1F, pointer wraps to 0
    wr(3'd7, 8'h5A);            // stores at 0x00, pointer -> 1
    rreg(8'h1F, rv); chk("R2 masked load + R4 store", {24'd0, rv}, 32'hA5);
    rreg(8'h00, rv); chk("R4 wrap to 0", {24'd0, rv}, 32'h5A);
    rd(3'd7, rv); chk("R4 read keeps pointer", {24'd0, rv}, 32'h5A);
    wr(3'd3, 8'h02); wr(3'd5, 8'h00); wr(3'd1, 8'h10);
    rd(3'd7, rv); chk("R1 stray offset ignored", {24'd0, rv}, 32'h0);
    rd(3'd6, rv); chk("R1 stray read is 0", {24'd0, rv}, 32'h0);
  endtask

  task automatic t_reset_cmd;
    wreg(8'h18, 8'h80);         // reset with single-byte flag set
    status_irq("R7 reset irq", 1'b1);
    rreg(8'h17, rv); chk("R7 reset CSR", {24'd0, rv}, 32'h01);
    status_irq("R5 CSR read clears", 1'b0);
  endtask

  task automatic t_ctrl_clear;
    wreg(8'h18, 8'h00);
    wreg(8'h01, 8'h04);
    status_irq("R6 ctrl without bit3", 1'b1);
    wreg(8'h01, 8'h08);
    status_irq("R6 ctrl bit3 clears", 1'b0);
  endtask

  task automatic t_select;
    wreg(8'h15, 8'h05);
    wreg(8'h18, 8'h06);
    status_irq("R8 sel irq", 1'b1);
    rreg(8'h17, rv); chk("R8 present target CSR", {24'd0, rv}, 32'h8A);
    wreg(8'h15, 8'h03);
    wreg(8'h18, 8'h86);
    rreg(8'h17, rv); chk("R8 absent target CSR", {24'd0, rv}, 32'h42);
  endtask

  task automatic t_unimpl;
    wreg(8'h18, 8'h00);         // CSR=0x01, irq set
    wreg(8'h18, 8'h55);
    status_irq("R12 unknown keeps irq", 1'b1);
    rreg(8'h17, rv); chk("R12 unknown keeps CSR", {24'd0, rv}, 32'h01);
  endtask

  task automatic t_xfer(input logic [7:0] n, input logic out_dir, input logic [7:0] exp_csr);
    tgt_wants_out = out_dir;
    wreg(8'h18, 8'h00);         // leave irq pending to see the clear
    wr(3'd3, 8'h12); wr(3'd7, 8'h00); wr(3'd7, 8'h00); wr(3'd7, n);
    wreg(8'h18, 8'h20);
    status_irq("R9 xfer clears irq", 1'b0);
    for (int i = 0; i < n; i++) begin
      wreg(8'h19, 8'h30 + 8'(i));
      chk("R10 byte valid", {31'd0, tgt_valid}, 32'd1);
      chk("R10 byte value", {24'd0, tgt_byte}, {24'd0, 8'h30 + 8'(i)});
      chk("R10 last flag", {31'd0, tgt_last}, (i == n - 1) ? 32'd1 : 32'd0);
      chk("R11 no err in xfer", {31'd0, err}, 32'd0);
    end
    status_irq("R10 done irq", 1'b1);
    wreg(8'h19, 8'hEE);
    chk("R11 err pulse", {31'd0, err}, 32'd1);
    chk("R11 no forward", {31'd0, tgt_valid}, 32'd0);
    status_irq("R11 irq kept", 1'b1);
    rreg(8'h17, rv); chk("R10/R11 CSR", {24'd0, rv}, {24'd0, exp_csr});
  endtask

  task automatic t_idle_data;
    wreg(8'h18, 8'h00);
    rreg(8'h17, rv);
    wreg(8'h19, 8'h11);
    chk("R11 idle data err", {31'd0, err}, 32'd1);
    status_irq("R11 idle irq unchanged", 1'b0);
    rreg(8'h17, rv); chk("R11 idle CSR unchanged", {24'd0, rv}, 32'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_pointer();
    t_reset_cmd();
    t_ctrl_clear();
    t_select();
    t_unimpl();
    t_xfer(8'd3, 1'b0, 8'h19);
    t_xfer(8'd1, 1'b1, 8'h18);
    t_idle_data();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule